// File: doc/BRIEF.md
# Synchronous Rectifier Gate Control Sequencer

This block is the digital timing core behind a synchronous-rectifier gate driver. Three comparator flags come in from the rectifier's drain-sense node and are already in logic form: sense is below the turn-on level, sense is above the turn-off level, and sense is above the reset level. The block retimes these flags and produces one gate-drive request. An undervoltage flag holds the block idle.

A conduction pulse starts when sense dips below the turn-on level. It may start only after a full blanking period with the gate low. Once the pulse starts, the turn-off comparator is masked for a programmable minimum on-time. After that, the pulse ends as soon as sense rises above the turn-off level. An optional maximum on-time can also cut the pulse short.

After each pulse, an off-time one-shot counts while sense stays above the reset level. Any dip below that level sends the count back to zero, so ringing stretches the blanking. The same mechanism locks the drive after power-up until one clean, uninterrupted off period has been seen. All durations are cycle counts and are clamped from below by floors. The floors come from the clock frequency.

Top module: `sr_gate_seq`

## Requirements
- R1: While `uvlo_i` is 1, `gate_o` is 0 from the next rising clock edge on. Both timers and the off-period qualification are cleared.
- R2: Each comparator flag passes through two flip-flops, and the gate register adds one more. A turn-on flag that arrives at the port therefore raises `gate_o` on the third rising edge, provided the off period is already qualified.
- R3: Once `gate_o` rises, it stays high for at least the effective minimum on-time in cycles. The turn-off flag has no effect during that window.
- R4: After the minimum on-time, a turn-off flag at the port lowers `gate_o` on the third rising edge.
- R5: The off period qualifies only after the synchronized reset-level flag has been 1 on the effective minimum off-time number of consecutive cycles, with the gate low. A single cycle at 0 restarts the count from zero. A turn-on flag before qualification is ignored.
- R6: When `uvlo_i` falls, no pulse is allowed until a complete, uninterrupted off period per R5 has elapsed.
- R7: When `max_on_en_i` is 1, `gate_o` falls after exactly the effective maximum on-time cycles, even with no turn-off flag. When it is 0, a pulse has no upper limit.
- R8: The effective minimum on-time is max(programmed, ceil(ON_FLOOR_NS·CLK_MHZ/1000)). The effective minimum off-time is max(programmed, ceil(OFF_FLOOR_NS·CLK_MHZ/1000)). The effective maximum on-time is never less than the effective minimum on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Undervoltage lockout active (synchronous level) |
| cs_below_on_i | input | 1 | Sense below turn-on level (asynchronous) |
| cs_above_off_i | input | 1 | Sense above turn-off level (asynchronous) |
| cs_above_rst_i | input | 1 | Sense above reset level (asynchronous) |
| min_on_cyc_i | input | CNT_W | Programmed minimum on-time, cycles |
| min_off_cyc_i | input | CNT_W | Programmed minimum off-time, cycles |
| max_on_cyc_i | input | CNT_W | Programmed maximum on-time, cycles |
| max_on_en_i | input | 1 | Enable forced turn-off at maximum on-time |
| gate_o | output | 1 | Gate-drive request |

## Verification
The hardest situation to reach is an off period that falls exactly one cycle short of qualification, and the same period completed exactly. Reaching it needs the reset-level flag held for a precise count through two synchronizer stages.

The stimulus first holds the reset-level flag low so that the count starts from a known zero. It then raises the flag for exactly floor−1 cycles and presents a turn-on, and repeats the sequence with exactly floor cycles. It also rings the flag repeatedly during start-up, so that every period is interrupted before it completes. A behavioural model sees the same delayed flags and judges the gate on every cycle.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  // Round a duration in ns up to whole cycles at the given clock rate, at least one cycle.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/sr_off_timer.sv
module sr_off_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             ok
);
  logic [CNT_W-1:0] cnt;
  logic             expire;

  assign expire = run && (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (!ok) begin
      if (!run) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (expire) ok <= 1'b1;
      end
    end
  end

  // R5
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok && !clr |=> ok);
  // R5
  ring_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !ok && !run |=> !ok);
endmodule

// File: rtl/sr_on_timer.sv
module sr_on_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] min_lim,
  input  logic [CNT_W-1:0] max_lim,
  output logic             min_done,
  output logic             max_hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nxt;

  assign nxt      = {1'b0, cnt} + (CNT_W+1)'(1);
  assign min_done = nxt >= {1'b0, min_lim};
  assign max_hit  = nxt >= {1'b0, max_lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int CNT_W        = 16,
  parameter int CLK_MHZ      = 100,
  parameter int ON_FLOOR_NS  = 55,
  parameter int OFF_FLOOR_NS = 245
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_i,
  input  logic             cs_below_on_i,
  input  logic             cs_above_off_i,
  input  logic             cs_above_rst_i,
  input  logic [CNT_W-1:0] min_on_cyc_i,
  input  logic [CNT_W-1:0] min_off_cyc_i,
  input  logic [CNT_W-1:0] max_on_cyc_i,
  input  logic             max_on_en_i,
  output logic             gate_o
);
  localparam int unsigned ON_FLOOR  = sr_gate_pkg::ns_to_cycles(ON_FLOOR_NS, CLK_MHZ);
  localparam int unsigned OFF_FLOOR = sr_gate_pkg::ns_to_cycles(OFF_FLOOR_NS, CLK_MHZ);
  localparam logic [CNT_W-1:0] ON_FLOOR_V  = CNT_W'(ON_FLOOR);
  localparam logic [CNT_W-1:0] OFF_FLOOR_V = CNT_W'(OFF_FLOOR);

  function automatic logic [CNT_W-1:0] at_least(logic [CNT_W-1:0] v, logic [CNT_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  logic [CNT_W-1:0] eff_min_on, eff_min_off, eff_max_on;
  logic [2:0]       flags_s;
  logic             s_on, s_off, s_rst;
  logic             gate_q, off_ok, min_done, max_hit;
  logic             turn_on_ev, cmp_off_ev, max_off_ev;

  assign eff_min_on  = at_least(min_on_cyc_i, ON_FLOOR_V);
  assign eff_min_off = at_least(min_off_cyc_i, OFF_FLOOR_V);
  assign eff_max_on  = at_least(max_on_cyc_i, eff_min_on);

  sr_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_above_rst_i, cs_above_off_i, cs_below_on_i}),
    .q(flags_s)
  );
  assign s_on  = flags_s[0];
  assign s_off = flags_s[1];
  assign s_rst = flags_s[2];

  sr_off_timer #(.CNT_W(CNT_W)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(uvlo_i || gate_q),
    .run(s_rst), .lim(eff_min_off), .ok(off_ok)
  );

  sr_on_timer #(.CNT_W(CNT_W)) u_on (
    .clk(clk), .rst_n(rst_n), .clr(uvlo_i || !gate_q),
    .min_lim(eff_min_on), .max_lim(eff_max_on),
    .min_done(min_done), .max_hit(max_hit)
  );

  assign turn_on_ev = !gate_q && s_on && off_ok;
  assign cmp_off_ev = gate_q && min_done && s_off;
  assign max_off_ev = gate_q && max_on_en_i && max_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gate_q <= 1'b0;
    else if (uvlo_i)                   gate_q <= 1'b0;
    else if (turn_on_ev)               gate_q <= 1'b1;
    else if (cmp_off_ev || max_off_ev) gate_q <= 1'b0;
  end

  assign gate_o = gate_q;

  // R1
  uvlo_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> !gate_q);
  // R6
  on_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(off_ok));
  // R3
  min_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q && !min_done && !uvlo_i |=> gate_q);
  // R7
  max_on_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q && max_on_en_i && max_hit |=> !gate_q);
endmodule

// File: tb/tb_sr_gate_seq.sv
module tb_sr_gate_seq;
  localparam int W = 16;
  localparam int MHZ = 50;
  localparam int FL_ON  = (55 * MHZ + 999) / 1000;
  localparam int FL_OFF = (245 * MHZ + 999) / 1000;

  logic clk = 0, rst_n = 0, uvlo = 1, c_on = 0, c_off = 1, c_rst = 1, max_en = 0;
  logic [W-1:0] min_on = 8, min_off = 20, max_on = 40;
  logic gate;

  sr_gate_seq #(.CNT_W(W), .CLK_MHZ(MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .cs_below_on_i(c_on),
    .cs_above_off_i(c_off), .cs_above_rst_i(c_rst), .min_on_cyc_i(min_on),
    .min_off_cyc_i(min_off), .max_on_cyc_i(max_on), .max_on_en_i(max_en),
    .gate_o(gate));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference: flags delayed two cycles, then decided each cycle.
  int q_on[$], q_off[$], q_rst[$];
  int m_gate = 0, m_k = 0, m_run = 0, m_ok = 0;
  string m_tag = "R1";

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  always @(posedge clk) begin
    int so, sf, sr, emin, eoff, emax;
    if (!rst_n) begin
      q_on = '{0, 0}; q_off = '{0, 0}; q_rst = '{0, 0};
      m_gate = 0; m_k = 0; m_run = 0; m_ok = 0; m_tag = "R1";
    end else begin
      so = q_on[0]; sf = q_off[0]; sr = q_rst[0];
      emin = mx(int'(min_on), FL_ON);
      eoff = mx(int'(min_off), FL_OFF);
      emax = mx(int'(max_on), emin);
      if (uvlo) begin
        m_gate = 0; m_k = 0; m_run = 0; m_ok = 0; m_tag = "R1";
      end else if (m_gate == 0) begin
        m_k = 0;
        if (so != 0 && m_ok != 0) begin m_gate = 1; m_tag = "R2"; end
        else m_tag = (so != 0) ? "R5" : "R6";
        if (m_ok == 0) begin
          if (sr == 0) m_run = 0;
          else begin m_run++; if (m_run >= eoff) m_ok = 1; end
        end
      end else begin
        m_run = 0; m_ok = 0;
        if (max_en && m_k + 1 >= emax) begin m_gate = 0; m_k = 0; m_tag = "R7"; end
        else if (m_k + 1 >= emin && sf != 0) begin m_gate = 0; m_k = 0; m_tag = "R4"; end
        else begin m_k++; m_tag = (m_k < emin) ? "R3" : "R4"; end
      end
      void'(q_on.pop_front()); void'(q_off.pop_front()); void'(q_rst.pop_front());
      q_on.push_back(int'(c_on)); q_off.push_back(int'(c_off)); q_rst.push_back(int'(c_rst));
    end
  end

  int hi_run = 0, last_w = 0, hi_total = 0;
  always @(negedge clk) begin
    chk(gate === m_gate[0], m_tag, int'(gate), m_gate);
    if (gate) begin hi_run++; hi_total++; end
    else if (hi_run != 0) begin last_w = hi_run; hi_run = 0; end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic arm(int n);   // qualified off period, gate low expected
    c_rst = 1; c_off = 1; c_on = 0; step(n);
  endtask

  task automatic fire();       // present turn-on
    c_rst = 0; c_off = 0; c_on = 1;
  endtask

  initial begin
    int base;
    step(5);
    rst_n = 1;
    step(2);
    chk(gate == 0, "R1", gate, 0);

    // R6: start-up with ringing, every period interrupted
    uvlo = 0;
    base = hi_total;
    for (int i = 0; i < 4; i++) begin
      c_rst = 1; c_on = 0; step(10);
      c_rst = 0; c_on = 1; step(3);
    end
    chk(hi_total == base, "R6", hi_total - base, 0);

    // R2: latency of turn-on after a complete period
    arm(25); fire();
    step(2); chk(gate == 0, "R2", gate, 0);
    step(1); chk(gate == 1, "R2", gate, 1);
    c_on = 0;

    // R4: turn-off latency after min-on
    step(20); chk(gate == 1, "R4", gate, 1);
    c_off = 1; c_rst = 1;
    step(2); chk(gate == 1, "R4", gate, 1);
    step(1); chk(gate == 0, "R4", gate, 0);

    // R5: ringing restarts the off period
    step(12); c_rst = 0; step(2); c_rst = 1; step(15);
    fire(); step(5); chk(gate == 0, "R5", gate, 0);
    arm(25); fire(); step(3); chk(gate == 1, "R5", gate, 1);

    // R3: turn-off flag ignored during min-on
    c_on = 0; c_off = 1; c_rst = 1; step(15);
    chk(last_w == 8, "R3", last_w, 8);

    // R7: forced turn-off at max-on
    max_en = 1;
    arm(25); fire(); step(60);
    chk(last_w == 40, "R7", last_w, 40);
    max_en = 0;
    arm(25); fire(); step(60);
    chk(gate == 1, "R7", gate, 1);
    c_off = 1; c_rst = 1; c_on = 0; step(5);
    chk(gate == 0, "R7", gate, 0);

    // R8: min-on floor
    min_on = 0;
    arm(25); c_rst = 0; c_on = 1; c_off = 1; step(3); c_on = 0; step(10);
    chk(last_w == FL_ON, "R8", last_w, FL_ON);

    // R8/R5: min-off floor, one cycle short then exact
    min_off = 0;
    c_rst = 0; c_on = 0; step(5);
    c_rst = 1; step(FL_OFF - 1);
    c_rst = 0; c_on = 1; step(5);
    chk(gate == 0, "R8", gate, 0);
    c_on = 0; step(3);
    c_rst = 1; step(FL_OFF);
    c_rst = 0; c_on = 1; c_off = 0; step(3);
    chk(gate == 1, "R8", gate, 1);
    c_on = 0; c_off = 1; c_rst = 1; step(10);

    // R8: max-on never below min-on
    min_on = 8; max_on = 2; max_en = 1; min_off = 20;
    arm(25); fire(); step(30);
    chk(last_w == 8, "R8", last_w, 8);
    max_en = 0; max_on = 40;

    // R1: lockout mid-pulse; R6: lockout exit needs a fresh period
    arm(25); fire(); step(10);
    chk(gate == 1, "R1", gate, 1);
    uvlo = 1; step(1);
    chk(gate == 0, "R1", gate, 0);
    step(3); uvlo = 0; base = hi_total;
    step(30);
    chk(hi_total == base, "R6", hi_total - base, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule